// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost-Empty Flag

The block is a first-in, first-out buffer whose write side and read side run on unrelated clocks. Words are stored on a rising write-clock edge when the write enable is high and the buffer has room. They are taken out on a rising read-clock edge when the read enable is high and a word is there. The write and read pointers cross between the domains as Gray code through two-flop synchronizers.

A master reset clears both pointers. While the reset is low, the block captures three settings, which then hold until the next master reset:
- the output mode, either standard or first-word-fall-through;
- the flag-timing mode, either synchronous or direct;
- the almost-empty offset n.

The almost-empty flag is computed in the read domain from the fill level. In standard mode it is high while n words or fewer remain. In first-word-fall-through mode the word waiting at the output also counts, so the threshold is n+1.

In the direct timing mode the flag follows the read-domain level without a register. In the synchronous timing mode it passes through one read-clock register. Because the write pointer crosses domains, the flag falls a few read-clock cycles after the write that lifts the level. Depending on where that write edge falls relative to the read clock, one extra read cycle of delay is allowed.

Top module: `dcfifo_ae`

## Requirements
- R1: While rst_ni is low, and after its release with no traffic, the outputs are empty_o=1, pae_o=1 and full_o=0.
- R2: A word is stored on a rising wclk_i edge when wen_i=1 and full_o=0, and words come out in the order they were written. The write-side Gray pointer changes by at most one bit per write-clock cycle.
- R3: A write attempted while full_o=1 is dropped: reading out afterwards yields only the words stored before it, and then empty_o=1.
- R4: In standard mode a read attempted while empty_o=1 does not move the read pointer: a word written afterwards is the next one read, and empty_o returns to 1 after it.
- R5: In standard mode, once both domains have settled, pae_o=1 exactly when the stored count is at most the offset. empty_o=1 exactly when the count is zero. In the direct timing mode empty_o=1 implies pae_o=1.
- R6: In first-word-fall-through mode rdata_o shows the oldest word whenever empty_o=0, and ren_i=1 removes it. Once settled, pae_o=1 exactly when the total count, including the word shown, is at most offset+1.
- R7: fwft_i, sync_flag_i and ae_offset_i are captured while rst_ni is low. Changing them after release has no effect until the next reset.
- R8: After a write lifts the count above the threshold, pae_o falls within a bounded number of rising rclk_i edges after that write edge. In the direct timing mode this is 2 or 3 edges, and in the synchronous timing mode 3 or 4.
- R9: When a read brings the count down to the threshold, pae_o rises in the direct timing mode right after the read edge. In the synchronous timing mode it rises one rclk_i edge later, and every rise there follows a word removal two read cycles earlier.
- R10: full_o=1 once 2**AW words are stored and both domains have settled. The read-domain fill level never exceeds 2**AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Active-low asynchronous master reset for both domains |
| fwft_i | input | 1 | Output mode captured at reset: 1 selects first-word-fall-through |
| sync_flag_i | input | 1 | Flag-timing mode captured at reset: 1 registers pae_o on rclk_i |
| ae_offset_i | input | AW | Almost-empty offset captured at reset |
| wen_i | input | 1 | Write enable, sampled on rising wclk_i |
| wdata_i | input | DW | Write data |
| full_o | output | 1 | Buffer full, write domain |
| ren_i | input | 1 | Read enable, sampled on rising rclk_i |
| rdata_o | output | DW | Read data |
| empty_o | output | 1 | No word available, read domain |
| pae_o | output | 1 | Almost-empty flag, high at or below the threshold |

## Verification
The assertions check four things on every cycle:
- a write refused while full leaves the write pointer unchanged;
- a standard-mode read refused while empty leaves the read pointer unchanged;
- the Gray pointer changes by at most one bit, and the read-side level stays in range;
- in the direct timing mode empty implies almost-empty, and in the synchronous timing mode each rise of the flag follows a word removal.

Several behaviours are shown only by the bench's scenarios:
- the threshold value in each output mode;
- the order of the data;
- the window of cross-domain latency before the flag falls;
- the one-edge difference between the two timing modes;
- the capture of the settings at reset.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef struct packed {
    logic fwft;
    logic sync_flag;
  } dcf_mode_t;
endpackage

// File: rtl/dcf_ptr_sync.sv
module dcf_ptr_sync #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  assign bin_o[W-1] = s2_q[W-1];
  for (genvar i = W - 2; i >= 0; i--) begin : g_g2b
    assign bin_o[i] = bin_o[i+1] ^ s2_q[i];
  end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int unsigned DW = 36,
  parameter int unsigned AW = 4
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wen_i,
  input  logic [AW:0]   rbin_i,
  output logic          full_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o
);
  logic [AW:0] wbin_q, wbin_d;

  assign full_o  = (wbin_q[AW] != rbin_i[AW]) && (wbin_q[AW-1:0] == rbin_i[AW-1:0]);
  assign we_o    = wen_i && !full_o;
  assign waddr_o = wbin_q[AW-1:0];
  assign wbin_d  = wbin_q + {{AW{1'b0}}, we_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_o <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_o <= wbin_d ^ (wbin_d >> 1);
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wen_i && full_o) |=> $stable(wbin_q));

  a_r2_gray_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wgray_o ^ $past(wgray_o)) <= 1);
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int unsigned DW = 36,
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  dcf_mode_t     mode_i,
  input  logic [AW-1:0] off_i,
  input  logic          ren_i,
  input  logic [AW:0]   wbin_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          pae_o
);
  localparam int unsigned DEPTH = 1 << AW;

  dcf_mode_t     mode_q;
  logic [AW-1:0] off_q;
  logic [AW:0]   rbin_q, rbin_d, ram_lvl;
  logic [AW+1:0] level, thr;
  logic          ram_empty, advance, consume, ovld_q, ovld_d, ae_now, pae_q;

  // settings captured while master reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= mode_i;
      off_q  <= off_i;
    end else begin
      mode_q <= mode_q;
      off_q  <= off_q;
    end
  end

  always_comb begin
    ram_lvl   = wbin_i - rbin_q;
    ram_empty = (ram_lvl == '0);
    if (mode_q.fwft) begin
      advance = !ram_empty && (!ovld_q || ren_i);
      consume = ren_i && ovld_q;
      empty_o = !ovld_q;
      ovld_d  = advance ? 1'b1 : (ren_i ? 1'b0 : ovld_q);
    end else begin
      advance = ren_i && !ram_empty;
      consume = advance;
      empty_o = ram_empty;
      ovld_d  = 1'b0;
    end
    rbin_d = rbin_q + {{AW{1'b0}}, advance};
    // the word shown at the output still counts toward the fill level
    level  = {1'b0, ram_lvl} + {{(AW+1){1'b0}}, ovld_q};
    thr    = {2'b00, off_q} + {{(AW+1){1'b0}}, mode_q.fwft};
    ae_now = (level <= thr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_o <= '0;
      ovld_q  <= 1'b0;
      rdata_o <= '0;
      pae_q   <= 1'b1;
    end else begin
      rbin_q  <= rbin_d;
      rgray_o <= rbin_d ^ (rbin_d >> 1);
      ovld_q  <= ovld_d;
      if (advance) rdata_o <= mem_rdata_i;
      pae_q   <= ae_now;
    end
  end

  assign raddr_o = rbin_q[AW-1:0];
  assign pae_o   = mode_q.sync_flag ? pae_q : ae_now;

  a_r4_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q.fwft && ren_i && empty_o) |=> $stable(rbin_q));

  a_r5_empty_implies_pae: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q.fwft && !mode_q.sync_flag && empty_o) |-> pae_o);

  a_r9_sync_rise_after_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.sync_flag && $rose(pae_o)) |-> $past(consume, 2));

  a_r10_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_lvl <= (AW+1)'(DEPTH));
endmodule

// File: rtl/dcfifo_ae.sv
module dcfifo_ae
  import dcf_pkg::*;
#(
  parameter int unsigned DW = 36,
  parameter int unsigned AW = 4
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          sync_flag_i,
  input  logic [AW-1:0] ae_offset_i,
  input  logic          wen_i,
  input  logic [DW-1:0] wdata_i,
  output logic          full_o,
  input  logic          ren_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          pae_o
);
  logic [AW:0]   wgray, rgray, wbin_r, rbin_w;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] mem_rdata;
  logic          we;
  dcf_mode_t     mode;

  assign mode = '{fwft: fwft_i, sync_flag: sync_flag_i};

  dcf_wr_ctl #(.AW(AW)) u_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .wen_i(wen_i), .rbin_i(rbin_w),
    .full_o(full_o), .we_o(we), .waddr_o(waddr), .wgray_o(wgray)
  );

  dcf_ptr_sync #(.W(AW+1)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .gray_i(wgray), .bin_o(wbin_r)
  );

  dcf_ptr_sync #(.W(AW+1)) u_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .gray_i(rgray), .bin_o(rbin_w)
  );

  dcf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk_i(wclk_i), .we_i(we), .waddr_i(waddr), .wdata_i(wdata_i),
    .raddr_i(raddr), .rdata_o(mem_rdata)
  );

  dcf_rd_ctl #(.DW(DW), .AW(AW)) u_rd (
    .clk_i(rclk_i), .rst_ni(rst_ni), .mode_i(mode), .off_i(ae_offset_i),
    .ren_i(ren_i), .wbin_i(wbin_r), .mem_rdata_i(mem_rdata),
    .raddr_o(raddr), .rgray_o(rgray), .rdata_o(rdata_o),
    .empty_o(empty_o), .pae_o(pae_o)
  );
endmodule

// File: tb/sim_dcfifo_ae.sv
`timescale 1ns/1ps
module sim_dcfifo_ae;
  localparam int DW = 36;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic fwft = 1'b0, syncm = 1'b0;
  logic [AW-1:0] off = '0;
  logic wen = 1'b0, ren = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic full, empty, pae;
  logic [DW-1:0] rdata;

  int n_chk = 0, n_fail = 0;
  bit cur_fwft;
  logic [DW-1:0] q[$];

  always #2.5 wclk = ~wclk;
  initial begin
    #1.3;
    forever #3.5 rclk = ~rclk;
  end

  dcfifo_ae #(.DW(DW), .AW(AW)) u0 (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .fwft_i(fwft),
    .sync_flag_i(syncm), .ae_offset_i(off), .wen_i(wen), .wdata_i(wdata),
    .full_o(full), .ren_i(ren), .rdata_o(rdata), .empty_o(empty), .pae_o(pae)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_pae(input int cnt, input int o, input bit fw);
    return cnt <= o + (fw ? 1 : 0);
  endfunction

  task automatic settle();
    repeat (10) @(negedge rclk);
  endtask

  // settings applied before reset; different values driven after release (R7)
  task automatic do_reset(input bit fw, input bit sm, input int o);
    @(negedge rclk);
    fwft = fw; syncm = sm; off = AW'(o);
    #1 rst_n = 1'b0;
    repeat (4) @(negedge rclk);
    rst_n = 1'b1;
    @(negedge rclk);
    fwft = ~fw; syncm = ~sm; off = (o == 0) ? AW'(DEPTH - 1) : '0;
    q.delete();
    cur_fwft = fw;
    repeat (3) @(negedge wclk);
  endtask

  task automatic write1(input logic [DW-1:0] d);
    @(negedge wclk);
    if (full) return;
    wen = 1'b1; wdata = d;
    @(negedge wclk);
    wen = 1'b0;
    q.push_back(d);
  endtask

  task automatic write_forced(input logic [DW-1:0] d);
    @(negedge wclk);
    wen = 1'b1; wdata = d;
    @(negedge wclk);
    wen = 1'b0;
  endtask

  task automatic read1(input string req);
    logic [DW-1:0] e;
    @(negedge rclk);
    if (empty || q.size() == 0) return;
    if (cur_fwft) chk(rdata == q[0], "R6", "head word shown", rdata, q[0]);
    ren = 1'b1;
    @(negedge rclk);
    ren = 1'b0;
    e = q.pop_front();
    if (!cur_fwft) chk(rdata == e, req, "read data order", rdata, e);
  endtask

  task automatic write_lat(input logic [DW-1:0] d, input int lo, input int hi);
    int n;
    bit seen;
    @(negedge wclk);
    wen = 1'b1; wdata = d;
    @(posedge wclk);
    wen <= 1'b0;
    q.push_back(d);
    n = 0; seen = 0;
    while (!seen && n < 10) begin
      @(posedge rclk);
      #0.2;
      n++;
      if (!pae) seen = 1;
    end
    chk(seen && n >= lo && n <= hi, "R8", "pae fall latency in rclk edges", n, lo);
  endtask

  task automatic pop_edge_check(input bit sm);
    @(negedge rclk);
    ren = 1'b1;
    @(negedge rclk);
    ren = 1'b0;
    void'(q.pop_front());
    if (sm) begin
      chk(pae == 1'b0, "R9", "sync mode pae before extra edge", pae, 0);
      @(negedge rclk);
      chk(pae == 1'b1, "R9", "sync mode pae after extra edge", pae, 1);
    end else begin
      chk(pae == 1'b1, "R9", "direct mode pae right after read", pae, 1);
    end
  endtask

  task automatic random_run(input bit fw, input bit sm, input int ops);
    int o;
    o = $urandom_range(0, DEPTH - 2);
    do_reset(fw, sm, o);
    for (int i = 0; i < ops; i++) begin
      if ($urandom_range(0, 1) == 0 && q.size() < DEPTH)
        write1(DW'({$urandom(), $urandom()}));
      else
        read1("R2");
      if (i % 60 == 59) begin
        settle();
        chk(pae == exp_pae(q.size(), o, fw), fw ? "R6" : "R5",
            "random settled pae", pae, exp_pae(q.size(), o, fw));
        chk(empty == (q.size() == 0), "R5", "random settled empty", empty, q.size() == 0);
      end
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));

    // R1 during and after reset
    fwft = 1'b0; syncm = 1'b0; off = 4'd3;
    repeat (3) @(negedge rclk);
    chk(empty && pae && !full, "R1", "flags in reset", {empty, pae, full}, 3'b110);
    do_reset(1'b0, 1'b0, 3);
    settle();
    chk(empty == 1'b1, "R1", "empty after reset", empty, 1);
    chk(pae == 1'b1, "R1", "pae after reset", pae, 1);
    chk(full == 1'b0, "R1", "full after reset", full, 0);

    // standard threshold, direct timing
    for (int i = 0; i < 3; i++) write1(DW'(36'h100 + i));
    settle();
    chk(pae == 1'b1, "R5", "std count at offset", pae, 1);
    chk(empty == 1'b0, "R5", "std not empty", empty, 0);
    write_lat(36'h103, 2, 3);
    settle();
    chk(pae == 1'b0, "R5", "std count above offset", pae, 0);
    while (q.size() > 0) read1("R2");
    settle();
    chk(empty && pae, "R5", "drained flags", {empty, pae}, 2'b11);

    // synchronous timing: latency and read-side rise
    do_reset(1'b0, 1'b1, 5);
    for (int i = 0; i < 5; i++) write1(DW'(36'h200 + i));
    settle();
    chk(pae == 1'b1, "R5", "sync mode count at offset", pae, 1);
    write_lat(36'h205, 3, 4);
    settle();
    pop_edge_check(1'b1);

    do_reset(1'b0, 1'b0, 5);
    for (int i = 0; i < 6; i++) write1(DW'(36'h300 + i));
    settle();
    chk(pae == 1'b0, "R9", "direct mode pae above threshold", pae, 0);
    pop_edge_check(1'b0);

    // first-word-fall-through threshold
    do_reset(1'b1, 1'b0, 2);
    for (int i = 0; i < 3; i++) write1(DW'(36'hA00 + i));
    settle();
    chk(pae == 1'b1, "R6", "fwft count at offset+1", pae, 1);
    chk(empty == 1'b0, "R6", "fwft word shown", empty, 0);
    chk(rdata == 36'hA00, "R6", "fwft head before read", rdata, 36'hA00);
    write1(36'hA03);
    settle();
    chk(pae == 1'b0, "R6", "fwft count above offset+1", pae, 0);
    while (q.size() > 0) read1("R6");
    settle();
    chk(empty == 1'b1, "R6", "fwft drained", empty, 1);

    // overflow and full
    do_reset(1'b0, 1'b0, 1);
    for (int i = 0; i < DEPTH; i++) write1(DW'(36'h5000 + i));
    settle();
    chk(full == 1'b1, "R10", "full at depth", full, 1);
    write_forced(36'hDEAD);
    settle();
    for (int i = 0; i < DEPTH; i++) read1("R3");
    settle();
    chk(empty == 1'b1, "R3", "no extra word after overflow", empty, 1);
    chk(full == 1'b0, "R10", "full cleared after drain", full, 0);

    // underflow
    do_reset(1'b0, 1'b0, 2);
    repeat (3) begin
      @(negedge rclk); ren = 1'b1;
      @(negedge rclk); ren = 1'b0;
    end
    settle();
    chk(empty == 1'b1, "R4", "still empty after empty reads", empty, 1);
    write1(36'h7777);
    settle();
    read1("R4");
    settle();
    chk(empty == 1'b1, "R4", "empty after single word", empty, 1);

    // settings held after reset release
    do_reset(1'b0, 1'b0, 2);
    for (int i = 0; i < 3; i++) write1(DW'(36'h900 + i));
    settle();
    chk(pae == 1'b0, "R7", "offset and mode held (3 words)", pae, 0);
    read1("R7");
    settle();
    chk(pae == 1'b1, "R7", "offset held (2 words)", pae, 1);

    random_run(1'b0, 1'b1, 300);
    random_run(1'b1, 1'b0, 300);
    random_run(1'b1, 1'b1, 300);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule